// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

A single-clock synchronous static memory with registered address, control and write data and a two-stage read pipeline. An access starts when one of two address strobes is asserted. One strobe always starts a read. The other starts a read or a write, chosen by the write controls. The next cycles then carry on at the burst address. An advance input either steps that address or holds it. The low two address bits count through a four-beat burst, in either linear or interleaved order. Per-lane write enables and a global write enable select which byte lanes are stored. In the parity build each lane is nine bits wide, and the ninth bit is stored and returned with its lane.

Three chip enables gate the start of a burst. The primary active-low enable masks the read-only strobe. The other two enables are only looked at when a strobe is asserted. An asynchronous output enable gates the read data onto the output, and the output carries a drive flag in place of a tri-state pad. A snooze input puts the memory to sleep after two sampled cycles. While asleep the memory accepts no access and keeps its contents and burst state. On wake it needs two recovery cycles before it accepts another access.

Top module: `sram_burst`

## Requirements
- R1: While rstN is low and after it is released, rdDrive is 0 and no burst is active, so continue cycles (both strobes high) perform no access until a strobe starts one.
- R2: adspN low with ce1N low, ce2 high and ce3N low loads addrIn and starts a read, whatever gwN, bweN and bwN show; the memory is not written in that cycle.
- R3: adscN low (with adspN high or masked) and all three enables valid loads addrIn and performs a write when any lane is enabled by R8, otherwise a read.
- R4: ce1N high masks adspN. With adspN masked or high, adscN low and any enable invalid deselects, and so does adspN low with ce1N low and either ce2 low or ce3N high. A deselect ends the burst and performs no access.
- R5: ce2 and ce3N are ignored in continue cycles; a burst goes on while they are invalid.
- R6: In a continue cycle advN low steps the burst count by one and advN high holds it. The access (read or write per R8) uses the resulting address. Only the two low address bits change, and they wrap within the aligned group of four.
- R7: With burstMode 0 the low bits of beat n are (start + n) mod 4; with burstMode 1 they are start XOR n.
- R8: gwN low enables every lane. Otherwise bweN low with bwN[i] low enables lane i, which is bits [i*LANE_W +: LANE_W] of wrData and rdData. With no lane enabled the cycle is a read.
- R9: With PARITY=1 each lane is 9 bits wide and its top bit is written and read back with the lane.
- R10: A read decoded at clock edge k presents its data after edge k+1. The data is the memory content before any write made at edge k+1.
- R11: rdDrive is 1 only while read data is presented, oeN is low (combinationally) and the memory is not asleep; rdData is 0 whenever rdDrive is 0.
- R12: When zz is sampled high at two consecutive edges, the memory is asleep from the second edge on. Every access presented at later edges is ignored until wake, and the memory contents and burst state are kept.
- R13: The edge that samples zz low while asleep, and the two edges after it, ignore all accesses; the third edge after it accepts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset of control and pipeline state |
| addrIn | input | ADDR_W | Word address loaded by a strobe |
| adspN | input | 1 | Read-only address strobe, active low, masked by ce1N |
| adscN | input | 1 | General address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| ce1N | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Second chip enable, active high, sampled only with a strobe |
| ce3N | input | 1 | Third chip enable, active low, sampled only with a strobe |
| gwN | input | 1 | Global write, active low: all lanes |
| bweN | input | 1 | Lane write qualifier, active low |
| bwN | input | LANES | Per-lane write enables, active low |
| burstMode | input | 1 | 0 linear, 1 interleaved burst order |
| zz | input | 1 | Snooze request, active high |
| oeN | input | 1 | Output enable, active low, asynchronous |
| wrData | input | LANES*LANE_W | Write data |
| rdData | output | LANES*LANE_W | Read data, zero when not driven |
| rdDrive | output | 1 | High when rdData would be driven onto the bus |

## Verification
The bench builds the block with ADDR_W=6, LANES=2 and PARITY=1. This gives 64 words of 18 bits, so the bench can preload every word and reach the parity bit of each lane. Burst wrap is tested at several aligned groups of four, including groups whose upper address bits must stay fixed. The array is small enough that the random phase revisits words often. That brings read-after-write ordering, lane merges and deselect-and-restart sequences into range many times over.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  typedef struct packed {
    logic rdGo;
    logic wrGo;
    logic asleep;
    logic blocked;
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_DESEL,
    OP_LOAD_RD,
    OP_LOAD,
    OP_CONT
  } burstOp_e;

  function automatic logic [1:0] beatLow(input logic [1:0] start,
                                         input logic [1:0] step,
                                         input logic interleave);
    beatLow = interleave ? (start ^ step) : 2'(start + step);
  endfunction

endpackage

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              burstMode,
  input  logic              zz,
  output ctlStrobes_t       strobes,
  output logic [LANES-1:0]  laneMask,
  output logic [ADDR_W-1:0] memAddr
);

  localparam int UP_W = ADDR_W - 2;

  logic            active;
  logic [UP_W-1:0] upperQ;
  logic [1:0]      baseQ;
  logic [1:0]      cnt;
  logic            entSeen;
  logic            asleep;
  logic [1:0]      recCnt;

  burstOp_e   op;
  logic [1:0] stepCnt;
  logic       wantsWrite;
  logic       blocked;

  always_comb begin
    laneMask   = gwN ? (bweN ? '0 : ~bwN) : '1;
    wantsWrite = |laneMask;
    blocked    = asleep || (recCnt != 2'd0);
    op         = OP_IDLE;
    stepCnt    = cnt;
    if (!blocked) begin
      if (!adspN && !ce1N) begin
        op = (ce2 && !ce3N) ? OP_LOAD_RD : OP_DESEL;
      end else if (!adscN) begin
        op = (!ce1N && ce2 && !ce3N) ? OP_LOAD : OP_DESEL;
      end else if (active) begin
        op      = OP_CONT;
        stepCnt = advN ? cnt : 2'(cnt + 2'd1);
      end
    end
    if (op == OP_LOAD_RD || op == OP_LOAD) begin
      memAddr = addrIn;
    end else begin
      memAddr = {upperQ, beatLow(baseQ, stepCnt, burstMode)};
    end
    strobes.rdGo    = (op == OP_LOAD_RD) ||
                      ((op == OP_LOAD || op == OP_CONT) && !wantsWrite);
    strobes.wrGo    = (op == OP_LOAD || op == OP_CONT) && wantsWrite;
    strobes.asleep  = asleep;
    strobes.blocked = blocked;
  end

  // burst state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      upperQ <= '0;
      baseQ  <= '0;
      cnt    <= '0;
    end else begin
      case (op)
        OP_LOAD_RD, OP_LOAD: begin
          active <= 1'b1;
          upperQ <= addrIn[ADDR_W-1:2];
          baseQ  <= addrIn[1:0];
          cnt    <= 2'd0;
        end
        OP_DESEL: active <= 1'b0;
        OP_CONT:  cnt <= stepCnt;
        default:  ;
      endcase
    end
  end

  // snooze entry and recovery
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entSeen <= 1'b0;
      asleep  <= 1'b0;
      recCnt  <= 2'd0;
    end else if (zz) begin
      if (!asleep) begin
        if (entSeen) begin
          asleep  <= 1'b1;
          entSeen <= 1'b0;
        end else begin
          entSeen <= 1'b1;
        end
        if (recCnt != 2'd0) recCnt <= recCnt - 2'd1;
      end
    end else begin
      entSeen <= 1'b0;
      if (asleep) begin
        asleep <= 1'b0;
        recCnt <= 2'd2;
      end else if (recCnt != 2'd0) begin
        recCnt <= recCnt - 2'd1;
      end
    end
  end

endmodule

// File: rtl/sram_burst_dp.sv
module sram_burst_dp
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             strobes,
  input  logic [LANES-1:0]        laneMask,
  input  logic [ADDR_W-1:0]       memAddr,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    oeN,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdDrive
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rdAddrQ;
  logic              rdPend;
  logic [DATA_W-1:0] dataQ;
  logic              validQ;

  always_ff @(posedge clk) begin
    if (strobes.wrGo) begin
      for (int l = 0; l < LANES; l++) begin
        if (laneMask[l]) mem[memAddr][l*LANE_W +: LANE_W] <= wrData[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPend <= 1'b0;
      validQ <= 1'b0;
    end else begin
      rdPend <= strobes.rdGo;
      validQ <= rdPend;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.rdGo) rdAddrQ <= memAddr;
    dataQ <= mem[rdAddrQ];
  end

  always_comb begin
    rdDrive = validQ && !oeN && !strobes.asleep;
    rdData  = rdDrive ? dataQ : '0;
  end

endmodule

// File: rtl/sram_burst.sv
module sram_burst
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int PARITY = 1,
  localparam int LANE_W = (PARITY != 0) ? 9 : 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              burstMode,
  input  logic              zz,
  input  logic              oeN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);

  ctlStrobes_t       strobes;
  logic [LANES-1:0]  laneMask;
  logic [ADDR_W-1:0] memAddr;

  sram_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .adspN(adspN), .adscN(adscN),
    .advN(advN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .burstMode(burstMode), .zz(zz), .strobes(strobes),
    .laneMask(laneMask), .memAddr(memAddr)
  );

  sram_burst_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .laneMask(laneMask),
    .memAddr(memAddr), .wrData(wrData), .oeN(oeN), .rdData(rdData),
    .rdDrive(rdDrive)
  );

endmodule

// File: rtl/sram_burst_chk.sv
module sram_burst_chk
  import sram_burst_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        adspN,
  input logic        adscN,
  input logic        ce1N,
  input logic        ce2,
  input logic        ce3N,
  input logic        gwN,
  input logic        bweN,
  input logic        oeN,
  input logic        rdDrive,
  input ctlStrobes_t strobes
);

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rstN)
    rdDrive |-> !oeN); // R11
  AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.asleep |-> !rdDrive); // R12
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.rdGo && strobes.wrGo)); // R3
  AST_ADSP_ALWAYS_READS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.blocked && !adspN && !ce1N && ce2 && !ce3N) |-> (strobes.rdGo && !strobes.wrGo)); // R2
  AST_ADSC_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.blocked && !adscN && ce1N) |-> (!strobes.rdGo && !strobes.wrGo)); // R4
  AST_NO_WRITE_UNENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (gwN && bweN) |-> !strobes.wrGo); // R8
  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && $past(strobes.rdGo, 2) && !oeN && !strobes.asleep) |-> rdDrive); // R10
  AST_BLOCKED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.blocked |-> (!strobes.rdGo && !strobes.wrGo)); // R13

endmodule

bind sram_burst sram_burst_chk u_chk (
  .clk(clk), .rstN(rstN), .adspN(adspN), .adscN(adscN), .ce1N(ce1N),
  .ce2(ce2), .ce3N(ce3N), .gwN(gwN), .bweN(bweN), .oeN(oeN),
  .rdDrive(rdDrive), .strobes(strobes)
);

// File: tb/sram_burst_tb.sv
module sram_burst_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              adspN = 1'b1, adscN = 1'b1, advN = 1'b1;
  logic              ce1N = 1'b1, ce2 = 1'b1, ce3N = 1'b0;
  logic              gwN = 1'b1, bweN = 1'b1;
  logic [LANES-1:0]  bwN = '1;
  logic              burstMode = 1'b0, zz = 1'b0, oeN = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              rdDrive;

  int    testCnt = 0;
  int    failCnt = 0;
  string curReq = "R1";
  bit    comparing = 1'b0;

  sram_burst #(.ADDR_W(ADDR_W), .LANES(LANES), .PARITY(1)) u_dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .adspN(adspN), .adscN(adscN),
    .advN(advN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .burstMode(burstMode), .zz(zz), .oeN(oeN), .wrData(wrData),
    .rdData(rdData), .rdDrive(rdDrive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  int mMem [DEPTH];
  bit mActive, mEnt, mAsleep, mPend, mValid;
  int mStart, mBeat, mRec, mPendAddr, mDataQ;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mActive = 0; mEnt = 0; mAsleep = 0; mRec = 0; mPend = 0; mValid = 0;
      mStart = 0; mBeat = 0;
    end else begin
      int mask, kind, addr, low, nextData;
      bit nextValid, blk, doRead, doWrite;
      nextData  = mMem[mPendAddr];
      nextValid = mPend;
      blk  = mAsleep || (mRec > 0);
      mask = !gwN ? 3 : (!bweN ? (~int'(bwN)) & 3 : 0);
      kind = 0; // 0 none, 1 read start, 2 general start, 3 continue, 4 deselect
      if (!blk) begin
        if (!adspN && !ce1N) kind = (ce2 && !ce3N) ? 1 : 4;
        else if (!adscN) kind = (!ce1N && ce2 && !ce3N) ? 2 : 4;
        else if (mActive) kind = 3;
      end
      doRead = 0; doWrite = 0; addr = 0;
      if (kind == 1 || kind == 2) begin
        mStart = int'(addrIn); mBeat = 0; mActive = 1; addr = mStart;
        doRead  = (kind == 1) || (mask == 0);
        doWrite = (kind == 2) && (mask != 0);
      end else if (kind == 3) begin
        if (!advN) mBeat = (mBeat + 1) % 4;
        low  = burstMode ? ((mStart % 4) ^ mBeat) : ((mStart % 4 + mBeat) % 4);
        addr = (mStart / 4) * 4 + low;
        doRead = (mask == 0); doWrite = (mask != 0);
      end else if (kind == 4) begin
        mActive = 0;
      end
      if (doWrite) begin
        for (int l = 0; l < LANES; l++)
          if (mask & (1 << l))
            mMem[addr] = (mMem[addr] & ~(511 << (9*l))) | (int'(wrData) & (511 << (9*l)));
      end
      mPend = doRead;
      if (doRead) mPendAddr = addr;
      mDataQ = nextData;
      mValid = nextValid;
      if (zz) begin
        if (!mAsleep) begin
          if (mEnt) begin mAsleep = 1; mEnt = 0; end else mEnt = 1;
          if (mRec > 0) mRec--;
        end
      end else begin
        mEnt = 0;
        if (mAsleep) begin mAsleep = 0; mRec = 2; end
        else if (mRec > 0) mRec--;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (comparing) begin
      bit expDrive;
      int expData;
      expDrive = mValid && !oeN && !mAsleep;
      expData  = expDrive ? mDataQ : 0;
      testCnt++;
      if (rdDrive !== expDrive || int'(rdData) !== expData) begin
        failCnt++;
        $display("FAIL %s at %0t: rdDrive=%0b rdData=%05h expected rdDrive=%0b rdData=%05h",
                 curReq, $time, rdDrive, rdData, expDrive, expData);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic quiet();
    adspN = 1; adscN = 1; advN = 1; ce1N = 0; ce2 = 1; ce3N = 0;
    gwN = 1; bweN = 1; bwN = '1;
  endtask

  task automatic deselect(int n);
    for (int i = 0; i < n; i++) begin
      quiet(); adscN = 0; ce1N = 1; tick();
    end
  endtask

  task automatic startC(int a, bit g, bit be, logic [1:0] bw, logic [DATA_W-1:0] d);
    quiet(); adscN = 0; addrIn = ADDR_W'(a); gwN = g; bweN = be; bwN = bw; wrData = d; tick();
  endtask

  task automatic startP(int a, bit g);
    quiet(); adspN = 0; addrIn = ADDR_W'(a); gwN = g; tick();
  endtask

  task automatic cont(bit adv, bit g, logic [DATA_W-1:0] d);
    quiet(); advN = adv; gwN = g; wrData = d; tick();
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mMem[i] = 0;
    mPendAddr = 0; mDataQ = 0;
    quiet();
    repeat (3) @(negedge clk);
    comparing = 1;
    // R1: reset state and no access while no burst is active
    curReq = "R1";
    testCnt++;
    if (rdDrive !== 1'b0) begin
      failCnt++;
      $display("FAIL R1 reset: rdDrive=%0b expected 0", rdDrive);
    end
    #1 rstN = 1;
    tick();
    for (int i = 0; i < 4; i++) cont(0, 1, '0);

    // R3: preload every word with a general-strobe write
    curReq = "R3";
    for (int a = 0; a < DEPTH; a++) startC(a, 0, 1, 2'b11, DATA_W'((a * 7919 + 13) & 18'h3FFFF));
    deselect(2);

    // R6 R7 R10: linear read burst across a group
    curReq = "R7_linear";
    burstMode = 0;
    startC(9, 1, 1, 2'b11, '0);
    for (int i = 0; i < 3; i++) cont(0, 1, '0);
    deselect(2);
    curReq = "R7_interleave";
    burstMode = 1;
    startC(9, 1, 1, 2'b11, '0);
    for (int i = 0; i < 3; i++) cont(0, 1, '0);
    deselect(2);
    burstMode = 0;

    // R6: suspend and wrap within the group
    curReq = "R6";
    startC(15, 1, 1, 2'b11, '0);
    cont(1, 1, '0); cont(1, 1, '0);
    for (int i = 0; i < 5; i++) cont(0, 1, '0);
    deselect(2);

    // R6 write burst then read back
    startC(40, 0, 1, 2'b11, 18'h2A5A5);
    cont(0, 0, 18'h15A5A); cont(0, 0, 18'h3C3C3); cont(0, 0, 18'h0F0F0);
    startC(40, 1, 1, 2'b11, '0);
    for (int i = 0; i < 3; i++) cont(0, 1, '0);
    deselect(2);

    // R8 R9: lane writes including the parity bits
    curReq = "R8_R9";
    startC(20, 1, 0, 2'b10, 18'h3FFFF);
    startC(21, 1, 0, 2'b01, 18'h3FFFF);
    startC(22, 1, 0, 2'b11, 18'h3FFFF);
    startC(23, 1, 1, 2'b00, 18'h3FFFF);
    startC(20, 1, 1, 2'b11, '0);
    for (int i = 0; i < 3; i++) cont(0, 1, '0);
    deselect(2);

    // R2: read-only strobe ignores write controls; follow-up continue writes
    curReq = "R2";
    startP(24, 0);
    cont(1, 0, 18'h1_2345);
    startC(24, 1, 1, 2'b11, '0);
    deselect(2);

    // R4: masking and deselect
    curReq = "R4";
    startC(28, 1, 1, 2'b11, '0);
    quiet(); adspN = 0; ce1N = 1; advN = 0; tick();
    quiet(); adscN = 0; ce1N = 1; tick();
    cont(0, 1, '0); cont(0, 1, '0);
    startC(28, 1, 1, 2'b11, '0);
    quiet(); adspN = 0; ce2 = 0; addrIn = 6'd3; tick();
    cont(0, 1, '0);
    quiet(); adspN = 0; ce3N = 1; addrIn = 6'd3; tick();
    quiet(); adscN = 0; ce2 = 0; addrIn = 6'd3; gwN = 0; wrData = 18'h3_0000; tick();
    cont(0, 1, '0);
    startC(3, 1, 1, 2'b11, '0);
    deselect(2);

    // R5: continue ignores second and third enables
    curReq = "R5";
    startC(32, 1, 1, 2'b11, '0);
    quiet(); advN = 0; ce2 = 0; ce3N = 1; tick();
    quiet(); advN = 0; ce2 = 0; tick();
    deselect(2);

    // R11: output enable gating
    curReq = "R11";
    startC(36, 1, 1, 2'b11, '0);
    cont(0, 1, '0);
    oeN = 1; cont(0, 1, '0);
    #2 oeN = 0;
    cont(0, 1, '0);
    #2 oeN = 1;
    deselect(1);
    oeN = 0;
    deselect(2);

    // R10: read followed at once by a write to the same word
    curReq = "R10";
    startC(44, 1, 1, 2'b11, '0);
    startC(44, 0, 1, 2'b11, 18'h0_ABCD);
    startC(44, 1, 1, 2'b11, '0);
    deselect(3);

    // R12: snooze keeps data and burst state
    curReq = "R12";
    startC(48, 1, 1, 2'b11, '0);
    zz = 1;
    cont(0, 1, '0);
    cont(0, 1, '0);
    for (int i = 0; i < 3; i++) startC(50 + i, 0, 1, 2'b11, 18'h3_1111);
    cont(0, 0, 18'h2_2222);
    // R13: recovery cycles
    curReq = "R13";
    zz = 0;
    startC(53, 0, 1, 2'b11, 18'h1_1111);
    startC(54, 0, 1, 2'b11, 18'h1_2222);
    startC(55, 0, 1, 2'b11, 18'h1_3333);
    startC(56, 0, 1, 2'b11, 18'h1_4444);
    for (int a = 48; a < 58; a++) startC(a, 1, 1, 2'b11, '0);
    deselect(3);

    // R8: mixed random traffic
    curReq = "R8_mixed";
    void'($urandom(32'h5EED));
    for (int i = 0; i < 500; i++) begin
      int op;
      op = $urandom % 10;
      quiet();
      addrIn = ADDR_W'($urandom);
      wrData = DATA_W'($urandom);
      advN = $urandom % 2;
      gwN = ($urandom % 4) != 0;
      bweN = $urandom % 2;
      bwN = LANES'($urandom);
      oeN = ($urandom % 8) == 0;
      burstMode = ($urandom % 16) == 0 ? ~burstMode : burstMode;
      if (($urandom % 40) == 0) zz = ~zz;
      if (op < 2) begin adspN = 0; ce1N = ($urandom % 6) == 0; end
      else if (op < 5) adscN = 0;
      ce2 = ($urandom % 8) != 0;
      ce3N = ($urandom % 8) == 0;
      if (op == 9) ce1N = 1;
      tick();
    end
    zz = 0; oeN = 0;
    deselect(4);
    comparing = 0;
    finishRun();
  end

endmodule